// File: doc/BRIEF.md
# Serial-In Shift Register with Output Latch

This block collects a serial bit stream in a chain of shift stages and, on a separate strobe, transfers the whole chain at once into a holding register that drives a parallel output bus. The parallel bus can be switched off, so several sources can share the same lines. The last shift stage is brought out as a serial cascade output. Feeding that output into the serial input of a second instance makes a wider register out of two or more instances.

The block runs on one system clock. The shift strobe and the latch strobe are level inputs, and the block acts on their rising transitions as seen at the system clock. An asynchronous active-low clear empties the shift stages only. The parallel outputs are driven as a data bus plus a per-bit drive-enable bus. The enclosing logic resolves these to a shared line.

Top module: `sr_latch_out`

## Requirements
- R1: While `rst_ni` is low, every shift stage and every holding bit is 0.
- R2: On a shift strobe rising edge with clear inactive, the stages become `{stages[W-2:0], ser_i}`. Stage 0 takes the serial input, and stage k takes the old stage k-1.
- R3: A low `clr_ni` zeroes all shift stages at once, without waiting for a clock edge, so `ser_o` goes to 0 straight away. The holding register keeps its value.
- R4: On a latch strobe rising edge, all W stages are copied together into the holding register. `par_o[k]` then shows stage k.
- R5: A strobe that stays high or falls leaves both registers unchanged. A shift strobe held high for several cycles shifts once only.
- R6: `oe_ni` high sets `par_oe_o` to all 0 (high impedance). `oe_ni` low sets it to all 1, so the pins drive the holding register. `oe_ni` changes neither register.
- R7: `ser_o` always equals the last shift stage (stage W-1), whatever the level of `oe_ni`.
- R8: When both strobes rise in the same cycle, the holding register takes the stage contents from before that shift.
- R9: In a chain of two instances, the first instance's `ser_o` feeds the second instance's `ser_i`. After 16 shifts of word w, sent MSB first, and one latch, `{par_o of second, par_o of first}` equals w.
- R10: A strobe rise seen at one clock edge updates the registers at that same edge. The outputs show the new value before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| ser_i | input | 1 | Serial data into stage 0 |
| shift_clk_i | input | 1 | Shift strobe; acts on its rising transition |
| latch_clk_i | input | 1 | Latch strobe; acts on its rising transition |
| clr_ni | input | 1 | Asynchronous active-low clear of the shift stages |
| oe_ni | input | 1 | Active-low output enable for the parallel bus |
| par_o | output | W | Holding-register contents |
| par_oe_o | output | W | Per-bit drive enable for `par_o` |
| ser_o | output | 1 | Cascade output, the last shift stage |

## Verification
Shift and latch results are due one system clock edge after a strobe is raised. The bench raises strobes on a falling edge, so the update lands on the next rising edge. It reads the outputs on the falling edge after that. Clear and output enable act without a clock edge, so the bench changes them in the middle of a cycle and reads the outputs 1 ns later, before any clock edge comes. The chain test waits for all 16 shifts and the single latch to complete before it reads both instances.

// File: rtl/sr_pkg.sv
package sr_pkg;
  parameter int unsigned DEF_WIDTH = 8;
  localparam int unsigned NUM_STB = 2;
  typedef enum int unsigned {STB_SHIFT = 0, STB_LATCH = 1} stb_e;
endpackage

// File: rtl/stb_rise.sv
module stb_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // reset to 1: a strobe already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/sr_chain.sv
module sr_chain #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_ni,
  input  logic         shift_i,
  input  logic         din_i,
  output logic [W-1:0] stages_o
);
  logic arst_n;
  logic [W-1:0] stages_q;

  assign arst_n = rst_ni & clr_ni;

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)      stages_q <= '0;
    else if (shift_i) stages_q <= {stages_q[W-2:0], din_i};
  end

  assign stages_o = stages_q;

  p_clear_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> stages_o == '0);
  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    shift_i |=> stages_o == {$past(stages_o[W-2:0]), $past(din_i)});
  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !shift_i |=> $stable(stages_o));
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hold_q <= '0;
    else if (load_i) hold_q <= din_i;
  end

  assign hold_o = hold_q;

  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> hold_o == $past(din_i));
  p_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hold_o));
endmodule

// File: rtl/sr_latch_out.sv
module sr_latch_out
  import sr_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         shift_clk_i,
  input  logic         latch_clk_i,
  input  logic         clr_ni,
  input  logic         oe_ni,
  output logic [W-1:0] par_o,
  output logic [W-1:0] par_oe_o,
  output logic         ser_o
);
  logic [NUM_STB-1:0] stb_lvl;
  logic [NUM_STB-1:0] stb_rise_w;
  logic [W-1:0]       stages;
  logic [W-1:0]       hold;

  assign stb_lvl[STB_SHIFT] = shift_clk_i;
  assign stb_lvl[STB_LATCH] = latch_clk_i;

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    stb_rise u_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (stb_lvl[g]),
      .rise_o (stb_rise_w[g])
    );
  end

  sr_chain #(.W(W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_ni   (clr_ni),
    .shift_i  (stb_rise_w[STB_SHIFT]),
    .din_i    (ser_i),
    .stages_o (stages)
  );

  hold_reg #(.W(W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stb_rise_w[STB_LATCH]),
    .din_i  (stages),
    .hold_o (hold)
  );

  assign par_o    = hold;
  assign par_oe_o = {W{~oe_ni}};
  assign ser_o    = stages[W-1];

  p_ser_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> !ser_o);
endmodule

// File: tb/test_sr_latch_out.sv
module test_sr_latch_out;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, shf = 1'b0, lat = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic cas_ser = 1'b0;
  logic [W-1:0] par, par_oe, c0_par, c0_oe, c1_par, c1_oe;
  logic ser_out, c0_ser, c1_ser;
  wire  [W-1:0] par_z;

  int total = 0, bad = 0;
  bit done = 0;
  logic [W-1:0] m_sr = '0, m_hold = '0;

  always #10 clk = ~clk;

  sr_latch_out #(.W(W)) i_sr_latch_out (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .shift_clk_i(shf),
    .latch_clk_i(lat), .clr_ni(clr_n), .oe_ni(oe_n),
    .par_o(par), .par_oe_o(par_oe), .ser_o(ser_out));

  sr_latch_out #(.W(W)) i_cas0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(cas_ser), .shift_clk_i(shf),
    .latch_clk_i(lat), .clr_ni(clr_n), .oe_ni(oe_n),
    .par_o(c0_par), .par_oe_o(c0_oe), .ser_o(c0_ser));

  sr_latch_out #(.W(W)) i_cas1 (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(c0_ser), .shift_clk_i(shf),
    .latch_clk_i(lat), .clr_ni(clr_n), .oe_ni(oe_n),
    .par_o(c1_par), .par_oe_o(c1_oe), .ser_o(c1_ser));

  for (genvar k = 0; k < W; k++) begin : g_res
    assign par_z[k] = par_oe[k] ? par[k] : 1'bz;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_shift(input logic b);
    @(negedge clk); ser = b; shf = 1'b1;
    @(negedge clk); shf = 1'b0;
    m_sr = {m_sr[W-2:0], b};
  endtask

  task automatic do_latch;
    @(negedge clk); lat = 1'b1;
    @(negedge clk); lat = 1'b0;
    m_hold = m_sr;
  endtask

  task automatic shift_byte(input logic [W-1:0] v);
    for (int i = W-1; i >= 0; i--) begin
      do_shift(v[i]);
      check("R2 R7 ser_o", {15'd0, ser_out}, {15'd0, m_sr[W-1]});
    end
  endtask

  task automatic t_reset;
    #1;
    check("R1 par", {8'd0, par}, {8'd0, m_hold});
    check("R1 ser", {15'd0, ser_out}, 16'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_shift_latch;
    shift_byte(8'hA5);
    check("R5 par before latch", {8'd0, par}, {8'd0, m_hold});
    do_latch;
    check("R4 R10 latch A5", {8'd0, par}, 16'h00A5);
    shift_byte(8'h3C);
    do_latch;
    check("R4 latch 3C", {8'd0, par}, 16'h003C);
  endtask

  task automatic t_steady;
    @(negedge clk); ser = 1'b1; shf = 1'b1;
    repeat (3) @(negedge clk);
    shf = 1'b0;
    m_sr = {m_sr[W-2:0], 1'b1};
    lat = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 hold after steady latch", {8'd0, par}, {8'd0, m_sr});
    lat = 1'b0; m_hold = m_sr;
    do_shift(1'b0);
    @(negedge clk);
    check("R5 falling latch no load", {8'd0, par}, {8'd0, m_hold});
    do_latch;
    check("R5 single shift on long strobe", {8'd0, par}, {8'd0, m_sr});
  endtask

  task automatic t_clear;
    shift_byte(8'h81);
    do_latch;
    #3 clr_n = 1'b0;
    #1;
    check("R3 ser_o zero at once", {15'd0, ser_out}, 16'd0);
    check("R3 hold kept", {8'd0, par}, 16'h0081);
    @(negedge clk); clr_n = 1'b1;
    m_sr = '0;
    do_latch;
    check("R3 stages zeroed", {8'd0, par}, 16'h0000);
  endtask

  task automatic t_oe;
    shift_byte(8'hC3);
    do_latch;
    #3 oe_n = 1'b1;
    #1;
    check("R6 hi-z", {8'd0, par_z}, {8'd0, 8'bzzzzzzzz});
    check("R6 oe bus off", {8'd0, par_oe}, 16'h0000);
    check("R7 ser_o with oe high", {15'd0, ser_out}, {15'd0, m_sr[W-1]});
    do_shift(1'b0);
    #3 oe_n = 1'b0;
    #1;
    check("R6 drive restored", {8'd0, par_z}, 16'h00C3);
    check("R6 oe bus on", {8'd0, par_oe}, 16'h00FF);
    do_latch;
    check("R6 stages kept", {8'd0, par}, {8'd0, m_sr});
  endtask

  task automatic t_both;
    shift_byte(8'h96);
    @(negedge clk); ser = 1'b1; shf = 1'b1; lat = 1'b1;
    @(negedge clk); shf = 1'b0; lat = 1'b0;
    check("R8 old contents latched", {8'd0, par}, 16'h0096);
    m_sr = {m_sr[W-2:0], 1'b1};
    do_latch;
    check("R8 next latch new", {8'd0, par}, 16'h002D);
  endtask

  task automatic t_cascade;
    logic [15:0] w = 16'hB71E;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); cas_ser = w[i]; shf = 1'b1;
      @(negedge clk); shf = 1'b0;
    end
    @(negedge clk); lat = 1'b1;
    @(negedge clk); lat = 1'b0;
    check("R9 cascade word", {c1_par, c0_par}, w);
  endtask

  initial begin
    t_reset;
    t_shift_latch;
    t_steady;
    t_clear;
    t_oe;
    t_both;
    t_cascade;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule